// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Transmitter

This block sends bytes over a clocked-synchronous serial link. Software writes a byte into a holding register. When the shift engine is free, the block moves that byte into a shift register and sends it on a data pin, least significant bit first, as an 8-bit frame. A serial clock goes with the data. The block either generates that clock from a programmable divider of the system clock, or follows a clock that arrives on an input pin.

Two flags report progress. One flag says the holding register is free again. The other flag says the link has gone quiet after the last frame. Each flag has its own enable, and together they form a level interrupt request. Because of the holding register, software can queue the next byte while the current one is still shifting. When it does, frames follow each other with no idle gap. Three receive-side error inputs act as a gate: while any of them is high, no frame is started.

Top module: `sync_serial_tx`

## Requirements
- R1: After reset the block is idle: `hold_empty_o`=1, `tx_end_o`=1, `txd_o`=1, `sck_o`=1, and both interrupt outputs are 0 while their enables are 0.
- R2: A write while `tx_en_i`=1 stores `wdata_i` and clears both flags on the same clock edge. A write while `tx_en_i`=0 has no effect, so nothing is sent after enabling.
- R3: When the engine is idle, the holding register is full, `tx_en_i`=1 and all error inputs are 0, the byte moves into the shift register and `hold_empty_o` returns to 1 on the next edge. Bits leave in order bit 0 first, bit 7 last.
- R4: In internal-clock mode (`ext_clk_i`=0), each frame has exactly 8 low pulses on `sck_o`. Each low phase and each high phase lasts `div_i`+1 system clocks. `txd_o` changes only when `sck_o` falls.
- R5: If the holding register is full and no error input is high when bit 7 is clocked, the next byte loads at once. The rising-edge spacing stays 2·(`div_i`+1) across the frame boundary.
- R6: Otherwise the frame ends: `tx_end_o` becomes 1, `txd_o` keeps the value of bit 7, and `sck_o` stays high.
- R7: `irq_empty_o` equals `irq_empty_en_i` AND `hold_empty_o`. `irq_end_o` equals `irq_end_en_i` AND `tx_end_o`.
- R8: While any of `ovr_err_i`, `frm_err_i`, `par_err_i` is 1, no frame starts. A second write made before the load replaces the pending byte, and only the newer byte is sent.
- R9: A write in the same cycle as a load keeps the new byte pending and sends it after the byte being loaded.
- R10: In external-clock mode (`ext_clk_i`=1), `sck_i` passes through a synchronizer. `txd_o` takes the next bit after each falling edge of `sck_i`, and each rising edge completes one bit. `sck_o` stays 1 in this mode.
- R11: Clearing `tx_en_i` in the middle of a frame aborts it on the next edge. The outputs return to the idle values given in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable |
| ext_clk_i | input | 1 | 1 selects the external serial clock |
| div_i | input | DIV_W | Half bit period minus one, in system clocks |
| irq_empty_en_i | input | 1 | Enable for the holding-register-free request |
| irq_end_en_i | input | 1 | Enable for the transmission-end request |
| wr_i | input | 1 | Write strobe for the holding register |
| wdata_i | input | DATA_W | Byte to send |
| ovr_err_i | input | 1 | Receive overrun error flag |
| frm_err_i | input | 1 | Receive framing error flag |
| par_err_i | input | 1 | Receive parity error flag |
| sck_i | input | 1 | External serial clock |
| sck_o | output | 1 | Generated serial clock, idles high |
| txd_o | output | 1 | Serial data |
| hold_empty_o | output | 1 | Holding register free |
| tx_end_o | output | 1 | Transmission finished |
| irq_empty_o | output | 1 | Holding-register-free request |
| irq_end_o | output | 1 | Transmission-end request |

## Verification
A CPU write can land in the same cycle as the transfer from the holding register to the shift register. That transfer happens either when an idle engine starts or when bit 7 completes. The bench provokes this by issuing two writes on consecutive clocks: the second write meets the load of the first byte. It judges the result by requiring both bytes on the wire, in order, with a constant clock spacing. Constrained-random writes with random delays also place writes next to frame ends. In each case the bench compares the received byte stream against its own queue of expected bytes.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_RUN  = 1'b1
  } sh_state_e;

  typedef enum logic {
    CLK_INT = 1'b0,
    CLK_EXT = 1'b1
  } clk_src_e;
endpackage

// File: rtl/sst_clkgen.sv
module sst_clkgen
  import sst_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_sel_i,
  input  logic             run_i,
  input  logic             need_fall_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             sck_i,
  output logic             fall_stb_o,
  output logic             rise_stb_o
);
  localparam int LAST = SYNC_STAGES - 1;

  clk_src_e         src;
  logic [DIV_W-1:0] cnt_q;
  logic [LAST:0]    sync_q;
  logic             prev_q;
  logic             hit;
  logic             ext_fall, ext_rise;

  assign src = clk_src_e'(ext_sel_i);
  assign hit = run_i && (src == CLK_INT) && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || (src == CLK_EXT) || hit) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b1;
        else         sync_q[g] <= sck_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b1;
        else         sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[LAST];
  end

  assign ext_fall = prev_q && !sync_q[LAST];
  assign ext_rise = !prev_q && sync_q[LAST];

  always_comb begin
    if (src == CLK_EXT) begin
      fall_stb_o = ext_fall;
      rise_stb_o = ext_rise;
    end else begin
      fall_stb_o = hit && need_fall_i;
      rise_stb_o = hit && !need_fall_i;
    end
  end

  AST_STB_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fall_stb_o && rise_stb_o)); // R4
  AST_INT_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !ext_sel_i) |-> !(fall_stb_o || rise_stb_o)); // R4
endmodule

// File: rtl/sst_holdreg.sv
module sst_holdreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              load_i,
  input  logic              end_i,
  input  logic              irq_empty_en_i,
  input  logic              irq_end_en_i,
  output logic [DATA_W-1:0] hold_o,
  output logic              empty_o,
  output logic              end_o,
  output logic              irq_empty_o,
  output logic              irq_end_o
);
  logic [DATA_W-1:0] hold_q;
  logic              empty_q, end_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      empty_q <= 1'b1;
      end_q   <= 1'b1;
    end else if (!en_i) begin
      empty_q <= 1'b1;
      end_q   <= 1'b1;
    end else begin
      if (wr_i) begin
        hold_q  <= wdata_i;
        empty_q <= 1'b0;
        end_q   <= 1'b0;
      end else begin
        if (load_i) empty_q <= 1'b1;
        if (end_i)  end_q   <= 1'b1;
      end
    end
  end

  assign hold_o      = hold_q;
  assign empty_o     = empty_q;
  assign end_o       = end_q;
  assign irq_empty_o = irq_empty_en_i && empty_q;
  assign irq_end_o   = irq_end_en_i && end_q;

  AST_WR_CLEARS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wr_i) |=> (!empty_o && !end_o)); // R2
  AST_LOAD_FREES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !wr_i) |=> empty_o); // R3
  AST_END_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_i && !wr_i) |=> end_o); // R6
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
  import sst_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] hold_i,
  input  logic              can_load_i,
  input  logic              fall_stb_i,
  input  logic              rise_stb_i,
  output logic              load_o,
  output logic              end_o,
  output logic              busy_o,
  output logic              need_fall_o,
  output logic              txd_o,
  output logic              sck_o
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  sh_state_e         state_q;
  logic [DATA_W-1:0] shreg_q;
  logic [IDX_W-1:0]  idx_q;
  logic              need_fall_q, txd_q, sck_q;
  logic              frame_end;

  assign frame_end = (state_q == SH_RUN) && !need_fall_q && rise_stb_i && (idx_q == LAST_IDX);
  assign load_o    = en_i && can_load_i && ((state_q == SH_IDLE) || frame_end);
  assign end_o     = en_i && frame_end && !can_load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= SH_IDLE;
      shreg_q     <= '0;
      idx_q       <= '0;
      need_fall_q <= 1'b0;
      txd_q       <= 1'b1;
      sck_q       <= 1'b1;
    end else if (!en_i) begin
      state_q     <= SH_IDLE;
      idx_q       <= '0;
      need_fall_q <= 1'b0;
      txd_q       <= 1'b1;
      sck_q       <= 1'b1;
    end else if (load_o) begin
      state_q     <= SH_RUN;
      shreg_q     <= hold_i;
      idx_q       <= '0;
      need_fall_q <= 1'b1;
      sck_q       <= 1'b1;
    end else if (end_o) begin
      state_q     <= SH_IDLE;
      need_fall_q <= 1'b0;
      sck_q       <= 1'b1;
    end else if (state_q == SH_RUN) begin
      if (need_fall_q && fall_stb_i) begin
        txd_q       <= shreg_q[idx_q];
        need_fall_q <= 1'b0;
        sck_q       <= 1'b0;
      end else if (!need_fall_q && rise_stb_i) begin
        sck_q       <= 1'b1;
        idx_q       <= idx_q + 1'b1;
        need_fall_q <= 1'b1;
      end
    end
  end

  assign busy_o      = (state_q == SH_RUN);
  assign need_fall_o = need_fall_q;
  assign txd_o       = txd_q;
  assign sck_o       = sck_q;

  // data may move only on a falling strobe
  AST_TXD_ONLY_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !fall_stb_i) |=> $stable(txd_q)); // R4
  AST_END_PARKS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> (sck_q && !busy_o)); // R6
  AST_DISABLE_IDLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!busy_o && txd_q && sck_q)); // R11
endmodule

// File: rtl/sync_serial_tx.sv
module sync_serial_tx
  import sst_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              ext_clk_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              irq_empty_en_i,
  input  logic              irq_end_en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ovr_err_i,
  input  logic              frm_err_i,
  input  logic              par_err_i,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              txd_o,
  output logic              hold_empty_o,
  output logic              tx_end_o,
  output logic              irq_empty_o,
  output logic              irq_end_o
);
  logic [DATA_W-1:0] hold;
  logic empty, ended, rx_err, can_load;
  logic load, frame_done, busy, need_fall;
  logic fall_stb, rise_stb, sck_int;

  assign rx_err   = ovr_err_i || frm_err_i || par_err_i;
  assign can_load = !empty && !rx_err;

  sst_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .en_i           (tx_en_i),
    .wr_i           (wr_i),
    .wdata_i        (wdata_i),
    .load_i         (load),
    .end_i          (frame_done),
    .irq_empty_en_i (irq_empty_en_i),
    .irq_end_en_i   (irq_end_en_i),
    .hold_o         (hold),
    .empty_o        (empty),
    .end_o          (ended),
    .irq_empty_o    (irq_empty_o),
    .irq_end_o      (irq_end_o)
  );

  sst_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (tx_en_i),
    .hold_i      (hold),
    .can_load_i  (can_load),
    .fall_stb_i  (fall_stb),
    .rise_stb_i  (rise_stb),
    .load_o      (load),
    .end_o       (frame_done),
    .busy_o      (busy),
    .need_fall_o (need_fall),
    .txd_o       (txd_o),
    .sck_o       (sck_int)
  );

  sst_clkgen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ext_sel_i   (ext_clk_i),
    .run_i       (busy && tx_en_i),
    .need_fall_i (need_fall),
    .div_i       (div_i),
    .sck_i       (sck_i),
    .fall_stb_o  (fall_stb),
    .rise_stb_o  (rise_stb)
  );

  assign sck_o        = ext_clk_i ? 1'b1 : sck_int;
  assign hold_empty_o = empty;
  assign tx_end_o     = ended;

  AST_ERR_BLOCKS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_err_i || frm_err_i || par_err_i) |-> !load); // R8
  AST_END_ONLY_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done |-> busy); // R6
  AST_SCK_HIGH_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && $past(!busy)) |-> sck_o); // R6
endmodule

// File: tb/sync_serial_tx_bench.sv
module sync_serial_tx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       tx_en = 0, ext_clk = 0, ie_empty = 0, ie_end = 0, wr = 0;
  logic [7:0] div = 8'd2, wdata = 8'h00;
  logic       ovr = 0, frm = 0, par = 0, sck_in = 1;
  logic       sck_o, txd_o, hold_empty_o, tx_end_o, irq_empty_o, irq_end_o;

  sync_serial_tx u_sync_serial_tx (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .ext_clk_i(ext_clk), .div_i(div),
    .irq_empty_en_i(ie_empty), .irq_end_en_i(ie_end), .wr_i(wr), .wdata_i(wdata),
    .ovr_err_i(ovr), .frm_err_i(frm), .par_err_i(par), .sck_i(sck_in),
    .sck_o(sck_o), .txd_o(txd_o), .hold_empty_o(hold_empty_o), .tx_end_o(tx_end_o),
    .irq_empty_o(irq_empty_o), .irq_end_o(irq_end_o)
  );

  int cyc = 0;
  int checks = 0, fails = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // receiver model: samples txd on each rising sck_o
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];
  int rise_q[$];
  int fall_q[$];
  int mon_bits = 0;
  logic [7:0] mon_byte = 8'h00;
  logic sck_prev = 1'b1;
  int clr_req = 0, clr_seen = 0;

  always @(negedge clk) begin
    if (clr_req != clr_seen) begin
      clr_seen = clr_req;
      got_q.delete(); rise_q.delete(); fall_q.delete();
      mon_bits = 0;
    end
    if (!sck_prev && sck_o) begin
      mon_byte[mon_bits[2:0]] = txd_o;
      rise_q.push_back(cyc);
      mon_bits++;
      if (mon_bits == 8) begin
        got_q.push_back(mon_byte);
        mon_bits = 0;
      end
    end
    if (sck_prev && !sck_o) fall_q.push_back(cyc);
    sck_prev = sck_o;
  end

  function automatic int half_len(input logic [7:0] d);
    return int'(d) + 1;
  endfunction

  function automatic int bit_len(input logic [7:0] d);
    return 2 * (int'(d) + 1);
  endfunction

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", cyc, 150000);
      report();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    tick(); wr = 1; wdata = b;
    tick(); wr = 0;
  endtask

  task automatic clear_mon();
    clr_req++;
    @(negedge clk);
    tick();
  endtask

  task automatic wait_end();
    @(negedge clk);
    while (!tx_end_o) @(negedge clk);
  endtask

  task automatic wait_empty();
    @(negedge clk);
    while (!hold_empty_o) @(negedge clk);
  endtask

  task automatic check_bytes(input string req);
    tick();
    chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    exp_q.delete();
    clear_mon();
  endtask

  task automatic check_low(input logic [7:0] d, input string req);
    tick();
    chk(fall_q.size() == rise_q.size(), req, fall_q.size(), rise_q.size());
    for (int i = 0; i < rise_q.size() && i < fall_q.size(); i++)
      chk(rise_q[i] - fall_q[i] == half_len(d), req, rise_q[i] - fall_q[i], half_len(d));
  endtask

  task automatic check_spacing(input logic [7:0] d, input string req);
    tick();
    for (int i = 1; i < rise_q.size(); i++)
      chk(rise_q[i] - rise_q[i-1] == bit_len(d), req, rise_q[i] - rise_q[i-1], bit_len(d));
  endtask

  initial begin
    void'($urandom(32'd7091));
    repeat (3) tick();
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(hold_empty_o == 1, "R1", hold_empty_o, 1);
    chk(tx_end_o == 1, "R1", tx_end_o, 1);
    chk(txd_o == 1, "R1", txd_o, 1);
    chk(sck_o == 1, "R1", sck_o, 1);
    chk(irq_empty_o == 0 && irq_end_o == 0, "R1", irq_empty_o, 0);

    // R2 write ignored while disabled
    wr_byte(8'h5A);
    repeat (10) tick();
    tx_en = 1;
    repeat (40) tick();
    @(negedge clk);
    chk(hold_empty_o == 1, "R2", hold_empty_o, 1);
    tick();
    chk(rise_q.size() == 0, "R2", rise_q.size(), 0);

    // single frame, internal clock: R3 R4 R6 R7
    ie_empty = 1; ie_end = 1; div = 8'd2;
    @(negedge clk);
    chk(irq_empty_o == 1 && irq_end_o == 1, "R7", irq_end_o, 1);
    exp_q.push_back(8'hA5);
    wr_byte(8'hA5);
    @(negedge clk);
    chk(hold_empty_o == 0, "R2", hold_empty_o, 0);
    chk(tx_end_o == 0, "R2", tx_end_o, 0);
    chk(irq_empty_o == 0 && irq_end_o == 0, "R7", irq_empty_o, 0);
    @(negedge clk);
    chk(hold_empty_o == 1, "R3", hold_empty_o, 1);
    chk(irq_empty_o == 1, "R7", irq_empty_o, 1);
    wait_end();
    chk(txd_o == 1, "R6", txd_o, 1);
    chk(sck_o == 1, "R6", sck_o, 1);
    chk(irq_end_o == 1, "R7", irq_end_o, 1);
    tick();
    chk(rise_q.size() == 8, "R4", rise_q.size(), 8);
    check_low(div, "R4");
    check_spacing(div, "R4");
    check_bytes("R3");

    // R5 back to back, last byte has bit 7 clear
    div = 8'd1;
    exp_q.push_back(8'h81); exp_q.push_back(8'h6E);
    wr_byte(8'h81);
    wait_empty();
    wr_byte(8'h6E);
    wait_end();
    chk(txd_o == 0, "R6", txd_o, 0);
    tick();
    chk(rise_q.size() == 16, "R5", rise_q.size(), 16);
    check_spacing(div, "R5");
    check_low(div, "R5");
    check_bytes("R5");

    // R9 write in the same cycle as the load
    div = 8'd0;
    exp_q.push_back(8'hC3); exp_q.push_back(8'h3A);
    tick(); wr = 1; wdata = 8'hC3;
    tick(); wdata = 8'h3A;
    tick(); wr = 0;
    wait_end();
    check_spacing(div, "R9");
    check_bytes("R9");

    // R8 error inputs block start; later write replaces pending byte
    div = 8'd1;
    par = 1;
    wr_byte(8'h11);
    wr_byte(8'h22);
    repeat (30) tick();
    @(negedge clk);
    chk(hold_empty_o == 0, "R8", hold_empty_o, 0);
    par = 0; ovr = 1;
    repeat (20) tick();
    frm = 1; ovr = 0;
    repeat (20) tick();
    chk(rise_q.size() == 0, "R8", rise_q.size(), 0);
    exp_q.push_back(8'h22);
    frm = 0;
    wait_end();
    check_bytes("R8");

    // R11 abort mid-frame
    begin
      int n_at_abort;
      div = 8'd3;
      wr_byte(8'hF0);
      @(negedge clk);
      while (rise_q.size() < 3) @(negedge clk);
      tick();
      tx_en = 0;
      @(posedge clk); @(negedge clk);
      chk(txd_o == 1, "R11", txd_o, 1);
      chk(sck_o == 1, "R11", sck_o, 1);
      chk(hold_empty_o == 1 && tx_end_o == 1, "R11", tx_end_o, 1);
      tick();
      n_at_abort = rise_q.size();
      tx_en = 1;
      repeat (50) tick();
      chk(rise_q.size() == n_at_abort, "R11", rise_q.size(), n_at_abort);
      clear_mon();
    end

    // R10 external clock
    begin
      logic [7:0] eb;
      eb = 8'h3C;
      ext_clk = 1;
      wr_byte(eb);
      repeat (4) tick();
      @(negedge clk);
      chk(hold_empty_o == 1, "R10", hold_empty_o, 1);
      chk(sck_o == 1, "R10", sck_o, 1);
      for (int i = 0; i < 8; i++) begin
        tick(); sck_in = 0;
        repeat (6) tick();
        @(negedge clk);
        chk(txd_o == eb[i], "R10", txd_o, eb[i]);
        tick(); sck_in = 1;
        repeat (6) tick();
      end
      repeat (4) tick();
      @(negedge clk);
      chk(tx_end_o == 1, "R10", tx_end_o, 1);
      chk(txd_o == eb[7], "R6", txd_o, eb[7]);
      tick();
      chk(rise_q.size() == 0, "R10", rise_q.size(), 0);
      ext_clk = 0;
      clear_mon();
    end

    // constrained random bursts, internal clock: R3 R4
    for (int k = 0; k < 6; k++) begin
      int nb;
      div = 8'($urandom_range(0, 3));
      nb = $urandom_range(3, 8);
      for (int j = 0; j < nb; j++) begin
        logic [7:0] b;
        wait_empty();
        repeat ($urandom_range(0, 20)) tick();
        b = 8'($urandom);
        exp_q.push_back(b);
        wr_byte(b);
      end
      wait_end();
      check_low(div, "R4");
      check_bytes("R3");
    end

    report();
    $finish;
  end
endmodule